// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Turn-On Dead Time

This block sequences the four gate-enable signals of a full bridge: the high and low switch of leg A and the high and low switch of leg B. A direction input picks which diagonal pair conducts. Direction high selects A-high with B-low. Direction low selects A-low with B-high. A global disable input turns every switch off. A high-side enable input, when low, keeps both high switches off and leaves the low switches under direction control. Disable outranks the high-side enable, and both outrank direction.

Each switch is released only after it has been requested for a programmable number of clock cycles. Turn-off takes effect at once. The high-side delay count serves both high switches, and the low-side delay count serves both low switches. When the direction reverses, the switches that were on drop on the same clock edge. The incoming switches then wait out their delay. This dead time is what stops both switches of one leg from conducting together. A request that is withdrawn before its delay has run out leaves no partial credit: the next request counts from zero.

Top module: `hbridge_deadtime`

## Requirements
- R1: While reset is asserted (rst_n low) all four gate outputs are low. After reset release the delay counters start from zero.
- R2: When dis_i is sampled high on a clock edge, all four outputs are low after that edge, whatever dir_i and hen_i are.
- R3: When hen_i is sampled low, a_hi_o and b_hi_o are low after that edge. a_lo_o and b_lo_o keep following dir_i.
- R4: dir_i = 1 requests a_hi_o and b_lo_o and keeps a_lo_o and b_hi_o off. dir_i = 0 requests a_lo_o and b_hi_o and keeps a_hi_o and b_lo_o off.
- R5: A requested high output rises after the (hs_dly_i + 1)-th consecutive clock edge on which it is requested. It stays high while the request lasts.
- R6: A requested low output rises after the (ls_dly_i + 1)-th consecutive clock edge on which it is requested. It stays high while the request lasts.
- R7: An output falls after the first clock edge on which its request is absent, with no added delay.
- R8: hs_dly_i governs both high outputs alike, and ls_dly_i governs both low outputs alike. A count of 0 turns the output on after the first requesting edge.
- R9: If a request is withdrawn before its output turned on, the next request counts its delay from zero again.
- R10: a_hi_o and a_lo_o are never high together, and b_hi_o and b_lo_o are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Direction: 1 = A-high/B-low diagonal, 0 = A-low/B-high diagonal |
| dis_i | input | 1 | Global disable, active high, top priority |
| hen_i | input | 1 | High-side enable, active high |
| hs_dly_i | input | DLY_W (8) | High-side turn-on delay in cycles |
| ls_dly_i | input | DLY_W (8) | Low-side turn-on delay in cycles |
| a_hi_o | output | 1 | Leg A high switch enable |
| a_lo_o | output | 1 | Leg A low switch enable |
| b_hi_o | output | 1 | Leg B high switch enable |
| b_lo_o | output | 1 | Leg B low switch enable |

## Verification
The bench reverses the direction while switches are on. A design that delayed turn-off, or did not reset the incoming counter, would overlap both switches of a leg or release a switch early. It uses unequal high and low delays, so that a design which swapped or shared the two counts would release a switch on the wrong cycle. It also uses zero delays, where an off-by-one counter would add a spare cycle. Withdrawn requests are checked for a count that restarts from zero rather than resuming. Disable is asserted together with a low high-side enable and changing direction, so a wrong priority would let a switch through.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;

   localparam int NUM_SW = 4;

   typedef enum logic [1:0] {
      SW_AH = 2'd0,
      SW_AL = 2'd1,
      SW_BH = 2'd2,
      SW_BL = 2'd3
   } sw_e;

   function automatic bit sw_is_high(input int idx);
      return (idx == int'(SW_AH)) || (idx == int'(SW_BH));
   endfunction

endpackage

// File: rtl/hbridge_steer.sv
module hbridge_steer
   import hbridge_pkg::*;
(
   input  logic              dir_i,
   input  logic              dis_i,
   input  logic              hen_i,
   output logic [NUM_SW-1:0] req_o
);

   always_comb begin
      req_o = '0;
      if (!dis_i) begin
         req_o[SW_AH] = dir_i & hen_i;
         req_o[SW_BL] = dir_i;
         req_o[SW_AL] = ~dir_i;
         req_o[SW_BH] = ~dir_i & hen_i;
      end
   end

endmodule

// File: rtl/hbridge_ontimer.sv
module hbridge_ontimer #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic             gate_o
);

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         gate_o <= 1'b0;
      end else if (!req_i) begin
         cnt_q  <= '0;
         gate_o <= 1'b0;
      end else if (!gate_o) begin
         if (cnt_q >= dly_i) begin
            gate_o <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/hbridge_deadtime.sv
module hbridge_deadtime
   import hbridge_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dir_i,
   input  logic             dis_i,
   input  logic             hen_i,
   input  logic [DLY_W-1:0] hs_dly_i,
   input  logic [DLY_W-1:0] ls_dly_i,
   output logic             a_hi_o,
   output logic             a_lo_o,
   output logic             b_hi_o,
   output logic             b_lo_o
);

   if (DLY_W < 1 || DLY_W > 16) begin : g_bad_width
      $error("hbridge_deadtime: DLY_W must lie in 1..16");
   end

   logic [NUM_SW-1:0] req;
   logic [NUM_SW-1:0] gate;

   hbridge_steer u_steer (
      .dir_i (dir_i),
      .dis_i (dis_i),
      .hen_i (hen_i),
      .req_o (req)
   );

   for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
      logic [DLY_W-1:0] dly_sel;
      if (sw_is_high(i)) begin : g_high
         assign dly_sel = hs_dly_i;
      end else begin : g_low
         assign dly_sel = ls_dly_i;
      end
      hbridge_ontimer #(.DLY_W(DLY_W)) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .req_i  (req[i]),
         .dly_i  (dly_sel),
         .gate_o (gate[i])
      );
   end

   assign a_hi_o = gate[SW_AH];
   assign a_lo_o = gate[SW_AL];
   assign b_hi_o = gate[SW_BH];
   assign b_lo_o = gate[SW_BL];

endmodule

// File: rtl/hbridge_deadtime_chk.sv
module hbridge_deadtime_chk (
   input logic clk,
   input logic rst_n,
   input logic dir_i,
   input logic dis_i,
   input logic hen_i,
   input logic a_hi_o,
   input logic a_lo_o,
   input logic b_hi_o,
   input logic b_lo_o
);

   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert ({a_hi_o, a_lo_o, b_hi_o, b_lo_o} == 4'b0000);
      end
   end

   // R10
   leg_a_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_hi_o && a_lo_o));

   // R10
   leg_b_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(b_hi_o && b_lo_o));

   // R2
   dis_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_i |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));

   // R3
   hen_blocks_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hen_i |=> !(a_hi_o || b_hi_o));

   // R4
   dir_high_blocks_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dir_i |=> !(a_lo_o || b_hi_o));

   // R4
   dir_low_blocks_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_i |=> !(a_hi_o || b_lo_o));

   // R5
   a_hi_rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a_hi_o) |-> $past(dir_i && hen_i && !dis_i));

   // R6
   a_lo_rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a_lo_o) |-> $past(!dir_i && !dis_i));

   // R7
   b_lo_drops_at_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_lo_o && !dir_i) |=> !b_lo_o);

endmodule

bind hbridge_deadtime hbridge_deadtime_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .dir_i  (dir_i),
   .dis_i  (dis_i),
   .hen_i  (hen_i),
   .a_hi_o (a_hi_o),
   .a_lo_o (a_lo_o),
   .b_hi_o (b_hi_o),
   .b_lo_o (b_lo_o)
);

// File: tb/hbridge_deadtime_tb.sv
`timescale 1ns/1ps
module hbridge_deadtime_tb;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       dir   = 1'b1;
   logic       dis   = 1'b0;
   logic       hen   = 1'b1;
   logic [7:0] hdly  = 8'd3;
   logic [7:0] ldly  = 8'd2;
   logic       a_hi, a_lo, b_hi, b_lo;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   // model state: index 0 AH, 1 AL, 2 BH, 3 BL
   int  run [4];
   bit  mon [4];

   hbridge_deadtime u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .dir_i    (dir),
      .dis_i    (dis),
      .hen_i    (hen),
      .hs_dly_i (hdly),
      .ls_dly_i (ldly),
      .a_hi_o   (a_hi),
      .a_lo_o   (a_lo),
      .b_hi_o   (b_hi),
      .b_lo_o   (b_lo)
   );

   always #5 clk = ~clk;

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // behavioural reference, updated on every rising edge
   always @(posedge clk) begin
      bit want [4];
      int lim;
      want[0] = !dis && dir && hen;
      want[1] = !dis && !dir;
      want[2] = !dis && !dir && hen;
      want[3] = !dis && dir;
      for (int k = 0; k < 4; k++) begin
         lim = (k == 0 || k == 2) ? int'(hdly) : int'(ldly);
         if (!rst_n || !want[k]) begin
            run[k] = 0;
            mon[k] = 1'b0;
         end else begin
            run[k] = run[k] + 1;
            if (run[k] >= lim + 1) mon[k] = 1'b1;
         end
      end
   end

   // per-cycle comparison and leg exclusivity
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 a_hi model", a_hi, mon[0]);
         chk("R6 a_lo model", a_lo, mon[1]);
         chk("R5 b_hi model", b_hi, mon[2]);
         chk("R6 b_lo model", b_lo, mon[3]);
         chk("R10 leg A overlap", a_hi && a_lo, 1'b0);
         chk("R10 leg B overlap", b_hi && b_lo, 1'b0);
      end
   end

   initial begin
      #1500000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      // R1: quiet in reset
      step(3);
      chk("R1 a_hi in reset", a_hi, 1'b0);
      chk("R1 a_lo in reset", a_lo, 1'b0);
      chk("R1 b_hi in reset", b_hi, 1'b0);
      chk("R1 b_lo in reset", b_lo, 1'b0);
      rst_n = 1'b1;
      step(2);
      chk("R6 b_lo before delay", b_lo, 1'b0);
      chk("R5 a_hi before delay", a_hi, 1'b0);
      step(1);
      chk("R6 b_lo after ldly+1", b_lo, 1'b1);
      chk("R5 a_hi still waiting", a_hi, 1'b0);
      step(1);
      chk("R1 a_hi counts from zero after reset", a_hi, 1'b1);

      // R7 and R4: direction reversal
      dir = 1'b0;
      step(1);
      chk("R7 a_hi off at once", a_hi, 1'b0);
      chk("R7 b_lo off at once", b_lo, 1'b0);
      chk("R4 a_lo not yet", a_lo, 1'b0);
      step(1);
      chk("R6 a_lo waiting", a_lo, 1'b0);
      step(1);
      chk("R4 a_lo on", a_lo, 1'b1);
      chk("R5 b_hi waiting", b_hi, 1'b0);
      step(1);
      chk("R4 b_hi on", b_hi, 1'b1);

      // R3: high-side enable override
      hen = 1'b0;
      step(1);
      chk("R3 b_hi forced off", b_hi, 1'b0);
      chk("R3 a_lo unaffected", a_lo, 1'b1);
      step(2);
      chk("R3 a_lo still on", a_lo, 1'b1);
      hen = 1'b1;
      step(3);
      chk("R9 b_hi restart after hen", b_hi, 1'b0);
      step(1);
      chk("R9 b_hi on after full delay", b_hi, 1'b1);

      // R2: disable outranks everything
      dis = 1'b1;
      step(1);
      chk("R2 a_lo off", a_lo, 1'b0);
      chk("R2 b_hi off", b_hi, 1'b0);
      hen = 1'b0;
      dir = 1'b1;
      step(2);
      chk("R2 a_hi off", a_hi, 1'b0);
      chk("R2 b_lo off", b_lo, 1'b0);

      // R8: zero delays
      dis  = 1'b0;
      hen  = 1'b1;
      hdly = 8'd0;
      ldly = 8'd0;
      step(1);
      chk("R8 a_hi zero delay", a_hi, 1'b1);
      chk("R8 b_lo zero delay", b_lo, 1'b1);
      dir = 1'b0;
      step(1);
      chk("R8 b_hi zero delay", b_hi, 1'b1);
      chk("R8 a_lo zero delay", a_lo, 1'b1);
      chk("R7 a_hi off on swap", a_hi, 1'b0);

      // R9: aborted request restarts
      hdly = 8'd5;
      dir  = 1'b1;
      step(3);
      chk("R9 a_hi partial", a_hi, 1'b0);
      dir = 1'b0;
      step(1);
      dir = 1'b1;
      step(5);
      chk("R9 a_hi no resumed count", a_hi, 1'b0);
      step(1);
      chk("R9 a_hi full count", a_hi, 1'b1);

      // R8: unequal delays shared per side
      hdly = 8'd2;
      ldly = 8'd6;
      dir  = 1'b0;
      step(1);
      dir = 1'b1;
      step(3);
      chk("R8 a_hi with hdly=2", a_hi, 1'b1);
      chk("R8 b_lo waiting ldly=6", b_lo, 1'b0);
      step(4);
      chk("R8 b_lo with ldly=6", b_lo, 1'b1);
      dir = 1'b0;
      step(3);
      chk("R8 b_hi with hdly=2", b_hi, 1'b1);
      chk("R8 a_lo waiting ldly=6", a_lo, 1'b0);
      step(4);
      chk("R8 a_lo with ldly=6", a_lo, 1'b1);

      // mixed stimulus against the model
      lfsr = 16'hACE1;
      for (int c = 0; c < 3000; c++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[3:0] == 4'd0) dir = ~dir;
         dis = (lfsr[9:5] == 5'd0);
         hen = (lfsr[14:11] != 4'd0);
         if (lfsr[8:4] == 5'd7) hdly = {5'd0, lfsr[2:0]};
         if (lfsr[8:4] == 5'd9) ldly = {5'd0, lfsr[15:13]};
         step(1);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule